// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches a bank of general-purpose input pins, arranged as groups of eight, and turns a configurable trigger condition on each pin into a sticky pending flag. Every pin has a 3-bit trigger code that selects one of five conditions: active-low level, active-high level, falling edge, rising edge or either edge. A per-group mask word decides which pending flags reach the single combined interrupt output. The pins are asynchronous to the block clock and pass through a two-flop synchroniser before any detection takes place.

Software reaches the state through a flat register port with word addresses. Writes take effect at the next clock edge. Reads are combinational from the address. There are three banks: trigger configuration, mask and pending. Each has one 32-bit word per group at a stride of four bytes. The interrupt handler reads pending and mask words in group order. It acknowledges a flag by writing a one to its bit position.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted and before any write, every configuration word reads 0, every mask word reads 0x000000FF (all eight pins masked), every pending word reads 0, and irq_o is low.
- R2: Group g's configuration, mask and pending words sit at byte addresses 0x700+4g, 0x900+4g and 0xA00+4g. Pin n's trigger code occupies bits 4n+2..4n of its configuration word, and bit 4n+3 always reads 0. Mask and pending words carry pin n at bit n, and bits 31..8 read 0. Any other address, including misaligned ones, reads 0 and a write to it changes nothing.
- R3: Code 0 (level low) and code 1 (level high) set the pending bit on every cycle the synchronised pin is at the active level. When an acknowledge of that bit falls in the same cycle, the bit stays set.
- R4: Code 2 sets pending on a 1-to-0 transition of the synchronised pin, code 3 sets it on a 0-to-1 transition, and code 4 sets it on either transition.
- R5: Codes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R6: Writing a pending word clears each bit written as 1. Bits written as 0 keep their value.
- R7: A pending bit is latched whether or not its mask bit is 1. A mask bit of 1 keeps that bit off irq_o, and clearing the mask bit raises irq_o for a flag that is already held.
- R8: irq_o is high exactly when, in some group, a pending bit is 1 and its mask bit is 0.
- R9: A pin change set up before clock edge k first shows in the pending bank, and on irq_o, after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Asynchronous pin inputs, group g pin n at bit 8g+n |
| addr_i | input | 12 | Register byte address |
| wr_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed sequences drive one pin per trigger code. They separate rising from falling from both-edge detection by checking which pending bits appear on each transition, and they separate level from edge behaviour by acknowledging while the level is still held. A cycle-exact probe after a single pin toggle tells a correct two-stage synchroniser from one that is too short or too long. Mask tests latch flags while masked and then unmask them, which separates gating at the output from gating at the latch. A long random phase mixes pin noise with random writes to every bank and compares every read and irq_o against a bench model built from the requirements. This exposes decode, field placement and clear-versus-set ordering errors.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  localparam int unsigned TRIG_W  = 3;
  localparam int unsigned FIELD_W = 4;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic [TRIG_W-1:0] code_i,
  input  logic              cur_i,
  input  logic              prev_i,
  output logic              hit_o
);
  always_comb begin
    hit_o = 1'b0;
    case (code_i)
      TRIG_LVL_LO: hit_o = ~cur_i;
      TRIG_LVL_HI: hit_o = cur_i;
      TRIG_FALL:   hit_o = prev_i & ~cur_i;
      TRIG_RISE:   hit_o = ~prev_i & cur_i;
      TRIG_BOTH:   hit_o = prev_i ^ cur_i;
      default:     hit_o = 1'b0; // codes 5..7 disabled
    endcase
  end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] cur_i,
  input  logic [PINS-1:0] prev_i,
  input  logic            cfg_we_i,
  input  logic            mask_we_i,
  input  logic            pend_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   cfg_rd_o,
  output logic [PINS-1:0] mask_o,
  output logic [PINS-1:0] pend_o,
  output logic            irq_o
);
  logic [TRIG_W-1:0] cfg_q [PINS];
  logic [PINS-1:0]   mask_q, pend_q, hit;
  logic [PINS-1:0]   clr;

  assign clr = pend_we_i ? wdata_i[PINS-1:0] : '0;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q[n] <= '0;
      else if (cfg_we_i) cfg_q[n] <= wdata_i[n*FIELD_W +: TRIG_W];
    end

    gpio_irq_trig u_trig (
      .code_i (cfg_q[n]),
      .cur_i  (cur_i[n]),
      .prev_i (prev_i[n]),
      .hit_o  (hit[n])
    );

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_we_i && wdata_i[n] && !hit[n] |=> !pend_q[n]); // R6
    AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[n] && !(pend_we_i && wdata_i[n]) |=> pend_q[n]); // R6
    AST_DISABLED_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q[n] && (cfg_q[n] > 3'd4) |=> !pend_q[n]); // R5
    AST_LEVEL_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[n] == 3'd1) && cur_i[n] |=> pend_q[n]); // R3
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i[PINS-1:0];
      pend_q <= (pend_q & ~clr) | hit; // set beats clear
    end
  end

  always_comb begin
    cfg_rd_o = '0;
    for (int n = 0; n < PINS; n++) cfg_rd_o[n*FIELD_W +: TRIG_W] = cfg_q[n];
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned   GROUPS    = 4,
  parameter int unsigned   PINS      = 8,
  parameter int unsigned   AW        = 12,
  parameter int unsigned   DW        = 32,
  parameter logic [AW-1:0] CFG_BASE  = 12'h700,
  parameter logic [AW-1:0] MASK_BASE = 12'h900,
  parameter logic [AW-1:0] PEND_BASE = 12'hA00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [GROUPS*PINS-1:0] pins_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 irq_o
);
  localparam int unsigned NPIN   = GROUPS * PINS;
  localparam int unsigned STRIDE = 4;

  logic [NPIN-1:0]   cur, prev;
  logic [GROUPS-1:0] sel_cfg, sel_mask, sel_pend, grp_irq;
  logic [DW-1:0]     cfg_rd  [GROUPS];
  logic [PINS-1:0]   mask_rd [GROUPS];
  logic [PINS-1:0]   pend_rd [GROUPS];
  logic [NPIN-1:0]   mask_all;

  gpio_irq_sync #(.W(NPIN)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins_i),
    .cur_o   (cur),
    .prev_o  (prev)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign sel_cfg[g]  = addr_i == CFG_BASE  + AW'(g * STRIDE);
    assign sel_mask[g] = addr_i == MASK_BASE + AW'(g * STRIDE);
    assign sel_pend[g] = addr_i == PEND_BASE + AW'(g * STRIDE);
    assign mask_all[g*PINS +: PINS] = mask_rd[g];

    gpio_irq_group #(.PINS(PINS), .DW(DW)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cur_i     (cur[g*PINS +: PINS]),
      .prev_i    (prev[g*PINS +: PINS]),
      .cfg_we_i  (wr_i & sel_cfg[g]),
      .mask_we_i (wr_i & sel_mask[g]),
      .pend_we_i (wr_i & sel_pend[g]),
      .wdata_i   (wdata_i),
      .cfg_rd_o  (cfg_rd[g]),
      .mask_o    (mask_rd[g]),
      .pend_o    (pend_rd[g]),
      .irq_o     (grp_irq[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (sel_cfg[g])  rdata_o |= cfg_rd[g];
      if (sel_mask[g]) rdata_o |= DW'(mask_rd[g]);
      if (sel_pend[g]) rdata_o |= DW'(pend_rd[g]);
    end
  end

  assign irq_o = |grp_irq;

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_cfg, sel_mask, sel_pend})); // R2
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_all) |-> !irq_o); // R7
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  gpio_irq_ctrl uut (
    .clk_i (clk), .rst_ni (rst_n), .pins_i (pins), .addr_i (addr),
    .wr_i (wr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  // reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_d, m_mask, m_pend;
  logic [2:0]  m_cfg [32];

  function automatic bit trig_hit(logic [2:0] c, logic s, logic d);
    case (c)
      3'd0: return !s;
      3'd1: return s;
      3'd2: return d && !s;
      3'd3: return !d && s;
      3'd4: return d ^ s;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] r = '0;
    for (int g = 0; g < 4; g++) begin
      if (a == 12'h700 + 12'(4*g))
        for (int n = 0; n < 8; n++) r[4*n +: 3] = m_cfg[8*g+n];
      if (a == 12'h900 + 12'(4*g)) r[7:0] = m_mask[8*g +: 8];
      if (a == 12'hA00 + 12'(4*g)) r[7:0] = m_pend[8*g +: 8];
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_d <= '0; m_mask <= '1; m_pend <= '0;
      for (int p = 0; p < 32; p++) m_cfg[p] <= '0;
    end else begin
      logic [31:0] nxt;
      m_s1 <= pins; m_s2 <= m_s1; m_d <= m_s2;
      nxt = m_pend;
      for (int g = 0; g < 4; g++) begin
        if (wr && addr == 12'hA00 + 12'(4*g)) nxt[8*g +: 8] = nxt[8*g +: 8] & ~wdata[7:0];
        if (wr && addr == 12'h900 + 12'(4*g)) m_mask[8*g +: 8] <= wdata[7:0];
        if (wr && addr == 12'h700 + 12'(4*g))
          for (int n = 0; n < 8; n++) m_cfg[8*g+n] <= wdata[4*n +: 3];
      end
      for (int p = 0; p < 32; p++) if (trig_hit(m_cfg[p], m_s2[p], m_d[p])) nxt[p] = 1'b1;
      m_pend <= nxt;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic chk_rd(logic [11:0] a, logic [31:0] e, string tag);
    addr = a; #1;
    n_chk++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic chk_irq(logic e, string tag);
    #1; n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    #1;
    for (int g = 0; g < 4; g++) begin
      chk_rd(12'h700 + 12'(4*g), 32'h0, "R1");
      chk_rd(12'h900 + 12'(4*g), 32'hFF, "R1");
      chk_rd(12'hA00 + 12'(4*g), 32'h0, "R1");
    end
    chk_irq(1'b0, "R1");
    tick(3);
    rst_n = 1'b1;

    for (int g = 0; g < 4; g++) wreg(12'h700 + 12'(4*g), 32'h55555555);
    tick(3);
    for (int g = 0; g < 4; g++) wreg(12'hA00 + 12'(4*g), 32'hFF);
    pins = 32'hA5C3_3C5A; tick(4);
    pins = 32'h0; tick(4);
    for (int g = 0; g < 4; g++) chk_rd(12'hA00 + 12'(4*g), 32'h0, "R5");

    wreg(12'h704, 32'hFFFFFFFF);
    chk_rd(12'h704, 32'h77777777, "R2");
    wreg(12'h704, 32'h55555555);
    chk_rd(12'h800, 32'h0, "R2");
    chk_rd(12'h710, 32'h0, "R2");
    chk_rd(12'h902, 32'h0, "R2");
    wreg(12'h902, 32'h0);
    chk_rd(12'h900, 32'hFF, "R2");

    // group 0: pin0 rising, pin1 falling, pin2 both
    wreg(12'h700, 32'h55555423);
    tick(3);
    wreg(12'hA00, 32'hFF);
    chk_rd(12'hA00, 32'h0, "R4");
    pins[2:0] = 3'b111; tick(3);
    chk_rd(12'hA00, 32'h05, "R4");
    wreg(12'hA00, 32'hFF);
    pins[2:0] = 3'b000; tick(3);
    chk_rd(12'hA00, 32'h06, "R4");
    wreg(12'hA00, 32'hFF);
    chk_rd(12'hA00, 32'h0, "R4");

    pins[0] = 1'b1;
    chk_rd(12'hA00, 32'h0, "R9");
    tick(1); chk_rd(12'hA00, 32'h0, "R9");
    tick(1); chk_rd(12'hA00, 32'h0, "R9");
    tick(1); chk_rd(12'hA00, 32'h01, "R9");

    wreg(12'hA00, 32'h00);
    chk_rd(12'hA00, 32'h01, "R6");
    wreg(12'hA00, 32'h02);
    chk_rd(12'hA00, 32'h01, "R6");
    chk_irq(1'b0, "R7");
    wreg(12'h900, 32'hFE);
    chk_irq(1'b1, "R7");
    chk_rd(12'h900, 32'hFE, "R7");
    wreg(12'hA00, 32'h01);
    chk_irq(1'b0, "R6");
    pins[1] = 1'b1; tick(3);
    pins[1] = 1'b0; tick(3);
    chk_rd(12'hA00, 32'h02, "R7");
    chk_irq(1'b0, "R7");
    wreg(12'h900, 32'hFC);
    chk_irq(1'b1, "R7");
    wreg(12'hA00, 32'hFF);
    wreg(12'h900, 32'hFF);

    // group 1: pin8 level high, pin9 level low
    wreg(12'h704, 32'h55555501);
    pins[9:8] = 2'b11; tick(3);
    wreg(12'hA04, 32'hFF);
    chk_rd(12'hA04, 32'h01, "R3");
    pins[8] = 1'b0; tick(3);
    wreg(12'hA04, 32'hFF);
    chk_rd(12'hA04, 32'h00, "R3");

    // group 3 drives the combined output
    wreg(12'h70C, 32'h55555553);
    wreg(12'hA0C, 32'hFF);
    wreg(12'h90C, 32'hFE);
    chk_irq(1'b0, "R8");
    pins[24] = 1'b1; tick(3);
    chk_irq(1'b1, "R8");
    chk_rd(12'hA0C, 32'h01, "R8");
    wreg(12'hA0C, 32'h01);
    chk_irq(1'b0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ra;
      @(negedge clk);
      if ($urandom_range(3) == 0) pins = $urandom;
      wr = ($urandom_range(9) < 3);
      case ($urandom_range(2))
        0: addr = 12'h700 + 12'(4 * $urandom_range(3));
        1: addr = 12'h900 + 12'(4 * $urandom_range(3));
        default: addr = 12'hA00 + 12'(4 * $urandom_range(3));
      endcase
      if ($urandom_range(7) == 0) addr = 12'($urandom);
      wdata = $urandom;
      ra = addr;
      #1; n_chk++;
      if (rdata !== exp_read(ra)) begin
        n_bad++;
        $display("FAIL R2 random addr=%h actual=%h expected=%h", ra, rdata, exp_read(ra));
      end
      n_chk++;
      if (irq !== (|(m_pend & ~m_mask))) begin
        n_bad++;
        $display("FAIL R8 random irq actual=%b expected=%b", irq, |(m_pend & ~m_mask));
      end
    end
    @(negedge clk); wr = 1'b0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule